// File: doc/BRIEF.md
# Slope Compensation Ramp Generator

This block produces the falling digital reference used by peak current mode control. On every PWM period sync pulse it reloads a 16-bit ramp from a programmed peak value. On each clock after that it lowers the ramp by a programmed slope step until the next sync pulse. The ramp value, or a fixed code, is turned into a 10-bit code for the comparator DAC. The analog DAC, the comparator and the power stage sit outside the block.

The peak value and the slope step are written into holding copies. They go live only on the sync pulse that reloads the ramp, so a PWM period always runs on a single consistent pair of settings. The ramp stops at zero instead of wrapping around. A comparator trip input can freeze the ramp at its present value for the rest of the period. One of several sync lines is chosen as the reload source.

Top module: `slopeRampGen`

## Requirements
- R1: When the selected sync line is high at a clock edge, the ramp output after that edge equals the peak value held in the peak holding copy before that edge.
- R2: On each clock edge with no sync, no trip and no freeze, the ramp decreases by the step value that went live at the most recent sync.
- R3: The ramp saturates at zero. When it is not greater than the step, the next decrement gives 0, and it stays at 0 until a sync.
- R4: A write to the peak or step holding copy does not change the running ramp. The value goes live at the next sync. A write in the same cycle as a sync goes live at the sync after that one.
- R5: The sync selector value k (0 to NUM_SYNC-1) makes only syncIn[k] a reload source. Pulses on the other lines have no effect. A selector value of NUM_SYNC or above selects no line.
- R6: A high trip input at an edge without sync holds the ramp at its value and freezes it until the next sync. Sync takes priority over trip in the same cycle.
- R7: The selection between ramp and fixed code is registered, with 1 meaning ramp. One edge after srcSelRamp is seen high, dacCode equals rampValue bits 15 down to 6.
- R8: One edge after srcSelRamp is seen low, dacCode equals fixedCode, and dacCode follows fixedCode combinationally from then on.
- R9: While rstN is low, the ramp, the holding copies, the live step and the source selection are all zero. As a result, dacCode equals fixedCode even if srcSelRamp is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | NUM_SYNC (3) | Candidate PWM period sync pulses |
| syncSel | input | clog2(NUM_SYNC) (2) | Chooses which sync line reloads the ramp |
| peakWr | input | 1 | Write strobe for the peak holding copy |
| peakData | input | RAMP_W (16) | Peak value to hold |
| stepWr | input | 1 | Write strobe for the step holding copy |
| stepData | input | RAMP_W (16) | Step value to hold |
| tripIn | input | 1 | Comparator trip; freezes the ramp until the next sync |
| srcSelRamp | input | 1 | 1 selects the ramp as DAC source, 0 selects the fixed code |
| fixedCode | input | DAC_W (10) | Fixed DAC code; 512 is the midpoint |
| rampValue | output | RAMP_W (16) | Current ramp value |
| dacCode | output | DAC_W (10) | Code sent to the comparator DAC |

## Verification
Every ramp effect (reload, decrement, saturation, freeze) reaches rampValue on the first clock edge after the inputs that cause it. A change of source selection reaches dacCode after one edge. fixedCode reaches dacCode with no delay once the fixed path is selected. The bench drives inputs on the falling edge and advances its reference model on the rising edge from the same values. It compares both outputs on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/slopeRampPkg.sv
package slopeRampPkg;
  typedef struct packed {
    logic load;
    logic hold;
    logic step;
  } rampStrobe_t;
endpackage

// File: rtl/slopeRampCtrl.sv
module slopeRampCtrl
  import slopeRampPkg::*;
#(
  parameter int NUM_SYNC = 3,
  localparam int SEL_W = $clog2(NUM_SYNC)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SYNC-1:0] syncIn,
  input  logic [SEL_W-1:0]    syncSel,
  input  logic                tripIn,
  output rampStrobe_t         strobe
);
  logic syncHit;
  logic frozenQ;

  always_comb begin
    syncHit = 1'b0;
    for (int i = 0; i < NUM_SYNC; i++) begin
      if (syncSel == SEL_W'(i)) syncHit = syncIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        frozenQ <= 1'b0;
    else if (syncHit) frozenQ <= 1'b0;
    else if (tripIn)  frozenQ <= 1'b1;
  end

  always_comb begin
    strobe.load = syncHit;
    strobe.hold = !syncHit && (frozenQ || tripIn);
    strobe.step = !syncHit && !frozenQ && !tripIn;
  end
endmodule

// File: rtl/slopeRampDatapath.sv
module slopeRampDatapath
  import slopeRampPkg::*;
#(
  parameter int RAMP_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobe,
  input  logic              peakWr,
  input  logic [RAMP_W-1:0] peakData,
  input  logic              stepWr,
  input  logic [RAMP_W-1:0] stepData,
  output logic [RAMP_W-1:0] rampQ
);
  logic [RAMP_W-1:0] peakShadow;
  logic [RAMP_W-1:0] stepShadow;
  logic [RAMP_W-1:0] stepLive;
  logic [RAMP_W-1:0] rampNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakShadow <= '0;
      stepShadow <= '0;
    end else begin
      if (peakWr) peakShadow <= peakData;
      if (stepWr) stepShadow <= stepData;
    end
  end

  always_comb begin
    rampNext = rampQ;
    if (strobe.load)      rampNext = peakShadow;
    else if (strobe.step) rampNext = (rampQ > stepLive) ? rampQ - stepLive : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampQ    <= '0;
      stepLive <= '0;
    end else begin
      rampQ <= rampNext;
      if (strobe.load) stepLive <= stepShadow;
    end
  end
endmodule

// File: rtl/slopeRampGen.sv
module slopeRampGen
  import slopeRampPkg::*;
#(
  parameter int RAMP_W   = 16,
  parameter int DAC_W    = 10,
  parameter int NUM_SYNC = 3
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SYNC-1:0]          syncIn,
  input  logic [$clog2(NUM_SYNC)-1:0]  syncSel,
  input  logic                         peakWr,
  input  logic [RAMP_W-1:0]            peakData,
  input  logic                         stepWr,
  input  logic [RAMP_W-1:0]            stepData,
  input  logic                         tripIn,
  input  logic                         srcSelRamp,
  input  logic [DAC_W-1:0]             fixedCode,
  output logic [RAMP_W-1:0]            rampValue,
  output logic [DAC_W-1:0]             dacCode
);
  localparam int DAC_LSB = RAMP_W - DAC_W;

  rampStrobe_t strobe;
  logic        srcRampQ;

  slopeRampCtrl #(.NUM_SYNC(NUM_SYNC)) uCtrl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncSel(syncSel),
    .tripIn(tripIn), .strobe(strobe)
  );

  slopeRampDatapath #(.RAMP_W(RAMP_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .peakWr(peakWr), .peakData(peakData),
    .stepWr(stepWr), .stepData(stepData),
    .rampQ(rampValue)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcRampQ <= 1'b0;
    else       srcRampQ <= srcSelRamp;
  end

  assign dacCode = srcRampQ ? rampValue[RAMP_W-1:DAC_LSB] : fixedCode;
endmodule

// File: rtl/slopeRampGenChk.sv
module slopeRampGenChk #(
  parameter int RAMP_W   = 16,
  parameter int DAC_W    = 10,
  parameter int NUM_SYNC = 3
)(
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_SYNC-1:0]         syncIn,
  input logic [$clog2(NUM_SYNC)-1:0] syncSel,
  input logic                        tripIn,
  input logic                        srcSelRamp,
  input logic [DAC_W-1:0]            fixedCode,
  input logic [RAMP_W-1:0]           rampValue,
  input logic [DAC_W-1:0]            dacCode
);
  logic selHit;
  always_comb begin
    selHit = 1'b0;
    for (int i = 0; i < NUM_SYNC; i++)
      if (int'(syncSel) == i && syncIn[i]) selHit = 1'b1;
  end

  // R3: without a reload the ramp never rises (no wrap below zero)
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !selHit |=> rampValue <= $past(rampValue));

  // R3: zero is sticky until a reload
  a_r3_zero_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rampValue == '0 && !selHit) |=> rampValue == '0);

  // R6: trip without sync holds the ramp
  a_r6_trip_hold: assert property (@(posedge clk) disable iff (!rstN)
    (tripIn && !selHit) |=> $stable(rampValue));

  // R7: ramp path gives the upper ramp bits
  a_r7_ramp_code: assert property (@(posedge clk) disable iff (!rstN)
    srcSelRamp |=> dacCode == rampValue[RAMP_W-1 -: DAC_W]);

  // R8: fixed path passes the fixed code
  a_r8_fixed_code: assert property (@(posedge clk) disable iff (!rstN)
    !srcSelRamp |=> dacCode == fixedCode);
endmodule

bind slopeRampGen slopeRampGenChk #(.RAMP_W(RAMP_W), .DAC_W(DAC_W), .NUM_SYNC(NUM_SYNC)) uChk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncSel(syncSel), .tripIn(tripIn),
  .srcSelRamp(srcSelRamp), .fixedCode(fixedCode), .rampValue(rampValue), .dacCode(dacCode)
);

// File: tb/tb_slopeRampGen.sv
module tb_slopeRampGen;
  localparam int RAMP_W = 16;
  localparam int DAC_W = 10;
  localparam int NUM_SYNC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic [NUM_SYNC-1:0] syncIn = '0;
  logic [1:0] syncSel = '0;
  logic peakWr = 1'b0, stepWr = 1'b0, tripIn = 1'b0, srcSelRamp = 1'b0;
  logic [RAMP_W-1:0] peakData = '0, stepData = '0;
  logic [DAC_W-1:0] fixedCode = 10'd512;
  logic [RAMP_W-1:0] rampValue;
  logic [DAC_W-1:0] dacCode;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R9";

  logic [RAMP_W-1:0] mRamp, mPeakSh, mStepSh, mStepLive;
  logic mFroz, mSrc;

  always #4 clk = ~clk;

  slopeRampGen #(.RAMP_W(RAMP_W), .DAC_W(DAC_W), .NUM_SYNC(NUM_SYNC)) dut (.*);

  function automatic logic selHitF();
    return (int'(syncSel) < NUM_SYNC) ? syncIn[syncSel] : 1'b0;
  endfunction

  function automatic logic [DAC_W-1:0] expDac();
    return mSrc ? mRamp[RAMP_W-1 -: DAC_W] : fixedCode;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (!rstN) begin
      mRamp = '0; mPeakSh = '0; mStepSh = '0; mStepLive = '0; mFroz = 0; mSrc = 0;
    end else begin
      if (selHitF()) begin
        mRamp = mPeakSh; mStepLive = mStepSh; mFroz = 0;
      end else if (mFroz || tripIn) begin
        mFroz = 1;
      end else begin
        mRamp = (mRamp > mStepLive) ? mRamp - mStepLive : '0;
      end
      if (peakWr) mPeakSh = peakData;
      if (stepWr) mStepSh = stepData;
      mSrc = srcSelRamp;
    end
    @(negedge clk);
    check({tag, " ramp"}, 32'(rampValue), 32'(mRamp));
    check({tag, " dac"}, 32'(dacCode), 32'(expDac()));
    syncIn = '0; peakWr = 0; stepWr = 0; tripIn = 0;
  endtask

  task automatic runN(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #1 rstN = 0;
    srcSelRamp = 1; fixedCode = 10'd300;
    tag = "R9"; runN(3);
    @(negedge clk) rstN = 1;
    srcSelRamp = 1; runN(1);

    // R1, R7: load peak and step, reload on selected line 2
    tag = "R1"; syncSel = 2;
    peakWr = 1; peakData = 16'hC000; stepWr = 1; stepData = 16'h0100; runN(1);
    syncIn = 3'b100; runN(1);
    tag = "R2"; runN(8);
    // R4: write new values mid-period, no effect until sync
    tag = "R4"; peakWr = 1; peakData = 16'h4000; stepWr = 1; stepData = 16'h0040; runN(5);
    syncIn = 3'b100; peakWr = 1; peakData = 16'h8000; runN(1);
    runN(4);
    syncIn = 3'b100; runN(3);
    // R5: unselected lines ignored, and out-of-range selector
    tag = "R5"; syncIn = 3'b011; runN(2);
    syncSel = 3; syncIn = 3'b111; runN(2);
    syncSel = 0; syncIn = 3'b001; runN(2);
    // R6: trip freezes; sync wins over trip
    tag = "R6"; tripIn = 1; runN(1); runN(4);
    syncIn = 3'b001; tripIn = 1; runN(1); runN(3);
    // R3: saturation at zero
    tag = "R3"; peakWr = 1; peakData = 16'h0250; stepWr = 1; stepData = 16'h0100; runN(1);
    syncIn = 3'b001; runN(6);
    // R8: fixed path and live fixedCode
    tag = "R8"; srcSelRamp = 0; runN(1);
    fixedCode = 10'd512; runN(1); fixedCode = 10'd1023; runN(1);
    tag = "R7"; srcSelRamp = 1; syncIn = 3'b001; peakWr = 1; peakData = 16'hFFC0; runN(3);

    tag = "RND";
    for (int i = 0; i < 3000; i++) begin
      syncSel = 2'($urandom_range(0, 3));
      syncIn = ($urandom_range(0, 15) == 0) ? 3'($urandom) : '0;
      tripIn = ($urandom_range(0, 40) == 0);
      peakWr = ($urandom_range(0, 20) == 0); peakData = 16'($urandom);
      stepWr = ($urandom_range(0, 20) == 0); stepData = 16'($urandom_range(0, 2048));
      if ($urandom_range(0, 50) == 0) srcSelRamp = ~srcSelRamp;
      if ($urandom_range(0, 50) == 0) fixedCode = 10'($urandom);
      cycle();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule